// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block is the control core of an extended-data-out DRAM, rebuilt as synchronous logic. The active-low row strobe, the lower and upper column strobes, write enable and output enable are sampled on a fast clock. Every memory cycle is sorted into a class, and a one-clock pulse marks each class as it is decided. Alongside the class code, the block produces per-byte-lane output drive enables, the row taken by the current cycle, and a wrapping 12-bit internal refresh row counter.

A small behavioural array holds one byte per lane for a few low row and column bits. This lets the read, write and byte-lane behaviour be observed at the ports. In page mode, read data stays on the pins after the column strobe rises. It is replaced or removed only at the next column strobe fall, or when output enable, write enable, or the end of the whole access turns the drivers off.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The internal column strobe is active while either lane strobe is low. It becomes active only when the first of the two falls and goes inactive only when both are high. Lane 0 (dq bits 7:0) follows `cas_ni[0]` and lane 1 (dq bits 15:8) follows `cas_ni[1]`. A lane's output drive can turn on only while its own strobe is low.
- R2: If the internal column strobe is active in the sample where the row strobe is first seen low, the cycle is a counter refresh (code 5). `row_o` takes the counter value, the counter advances by one modulo 4096, and `addr_i` is ignored.
- R3: A row strobe fall with both lane strobes high, followed by a row strobe rise with no column strobe activity in between, is a row-only refresh (code 4). The pulse comes on the rise, `row_o` holds the address sampled at the fall, and the counter does not move.
- R4: In a normal cycle, a read (code 1) is decided in the sample where the later of the column strobe fall and the output enable fall is seen, while write enable is high. From the next clock, data from the addressed location is driven on the lanes whose strobe is low, and only while output enable stays low.
- R5: Write enable low at the column strobe fall gives an early write (code 2). `dq_i` is written on the lanes whose strobe is low, and no lane drives for the rest of the cycle.
- R6: Write enable falling while the column strobe is already low gives a late write (code 3). The write goes to the column latched at the strobe fall, and the outputs are off while write enable is low or output enable is high.
- R7: After a read, the data stays driven when the column strobe rises while the row strobe stays low. The next column strobe fall either replaces the data with a new read or turns the lane off.
- R8: The outputs turn off in the clock after a sample where both the row strobe and the internal column strobe are high.
- R9: With the column strobe held low since a read or write, a row strobe rise and fall gives a hidden refresh (code 6). The counter advances, and the data already driven stays driven.
- R10: Class codes are: idle 0, read 1, early write 2, late write 3, row-only refresh 4, counter refresh 5, hidden refresh 6. `cyc_valid_o` pulses for one clock, one clock after the deciding sample, with `cyc_kind_o` set to the class. With no event, the code returns to 0 once both strobes are high and holds otherwise.
- R11: After reset the class is 0, there is no pulse, no lane drives, and the counter and `row_o` are 0.
- R12: Each internal column strobe fall latches a new column from `addr_i`, so several columns can be accessed within one row strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 2 | Lane column strobes, active low; bit 0 lower, bit 1 upper |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 12 | Multiplexed row / column address |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data, valid on driven lanes |
| dq_oe_o | output | 2 | Per-lane output drive enable |
| cyc_kind_o | output | 3 | Class of the latest decided cycle |
| cyc_valid_o | output | 1 | One-clock pulse per decided cycle |
| row_o | output | 12 | Row used by the current cycle |
| rfsh_ctr_o | output | 12 | Next internal refresh row |

## Verification
The embedded properties check the following on every clock: at most one class is decided per sample, a pulse never carries the idle code, the counter steps by exactly one per refresh and stays still otherwise, and a refresh row equals the prior counter value. They also check that a lane switches on only under its own strobe and goes dark after output enable rises or all strobes rise, and that no lane drives as an early write is reported. Only the bench scenarios can show the strobe-ordering cases: the dual-strobe merge, the hold of page-mode data, hidden refresh keeping data on the pins, late write reusing the latched column, and counter wrap.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_RD     = 3'd1,
    CYC_EWR    = 3'd2,
    CYC_LWR    = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_HIDDEN = 3'd6
  } cyc_kind_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/dcd_sampler.sv
module dcd_sampler #(
  parameter int unsigned NSIG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSIG-1:0] act_i,
  output logic [NSIG-1:0] prev_o
);
  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_o[g] <= 1'b0;
      else         prev_o[g] <= act_i[g];
    end
  end
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier import dcd_pkg::*; #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_ROW_W = 2,
  parameter int unsigned MEM_COL_W = 2,
  localparam int unsigned IDX_W    = MEM_ROW_W + MEM_COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_act_i,
  input  logic              cas_act_i,
  input  logic              we_act_i,
  input  logic              oe_act_i,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_fall_i,
  input  logic              we_fall_i,
  input  logic              oe_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ctr_i,
  output logic              rd_evt_o,
  output logic              wr_evt_o,
  output logic              rfsh_evt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] row_o,
  output cyc_kind_e         kind_o,
  output logic              valid_o
);
  logic                 cyc_q, ref_q, cas_seen_q, acc_q;
  logic [ADDR_W-1:0]    row_q;
  logic [MEM_COL_W-1:0] col_q, col_eff;
  cyc_kind_e            kind_q, evt_kind;
  logic                 valid_q;
  logic                 norm, ev_rd, ev_ewr, ev_lwr, ev_rf, ev_ro, any_evt;

  // normal access window: row opened with column strobe idle
  assign norm   = cyc_q & ~ref_q & ras_act_i;
  assign ev_rd  = norm & cas_act_i & oe_act_i & ~we_act_i & (cas_fall_i | oe_fall_i);
  assign ev_ewr = norm & cas_fall_i & we_act_i;
  assign ev_lwr = norm & cas_act_i & ~cas_fall_i & we_fall_i;
  assign ev_rf  = ras_fall_i & cas_act_i;
  assign ev_ro  = ras_rise_i & cyc_q & ~cas_seen_q & ~cas_act_i;
  assign any_evt = ev_rd | ev_ewr | ev_lwr | ev_rf | ev_ro;

  always_comb begin
    evt_kind = CYC_IDLE;
    if (ev_rf)       evt_kind = acc_q ? CYC_HIDDEN : CYC_CBR;
    else if (ev_rd)  evt_kind = CYC_RD;
    else if (ev_ewr) evt_kind = CYC_EWR;
    else if (ev_lwr) evt_kind = CYC_LWR;
    else if (ev_ro)  evt_kind = CYC_RONLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q      <= 1'b0;
      ref_q      <= 1'b0;
      cas_seen_q <= 1'b0;
      acc_q      <= 1'b0;
    end else begin
      if (ras_fall_i) begin
        cyc_q <= ~cas_act_i;
        ref_q <= cas_act_i;
      end else if (ras_rise_i) begin
        cyc_q <= 1'b0;
        ref_q <= 1'b0;
      end
      if (ras_fall_i)     cas_seen_q <= 1'b0;
      else if (cas_act_i) cas_seen_q <= 1'b1;
      if (!cas_act_i)                      acc_q <= 1'b0;
      else if (ev_rd | ev_ewr | ev_lwr)    acc_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ev_rf)           row_q <= ctr_i;
      else if (ras_fall_i) row_q <= addr_i;
      if (cas_fall_i)      col_q <= addr_i[MEM_COL_W-1:0];
    end
  end

  assign col_eff = cas_fall_i ? addr_i[MEM_COL_W-1:0] : col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CYC_IDLE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= any_evt;
      if (any_evt)                      kind_q <= evt_kind;
      else if (!ras_act_i && !cas_act_i) kind_q <= CYC_IDLE;
    end
  end

  assign rd_evt_o   = ev_rd;
  assign wr_evt_o   = ev_ewr | ev_lwr;
  assign rfsh_evt_o = ev_rf;
  assign idx_o      = {row_q[MEM_ROW_W-1:0], col_eff};
  assign row_o      = row_q;
  assign kind_o     = kind_q;
  assign valid_o    = valid_q;

  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_rd, ev_ewr, ev_lwr, ev_rf, ev_ro})); // R10
  AST_VALID_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> kind_q != CYC_IDLE); // R10
  AST_ROW_FROM_CTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rf |=> row_q == $past(ctr_i)); // R2
endmodule

// File: rtl/dcd_lane.sv
module dcd_lane import dcd_pkg::*; #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_act_i,
  input  logic              ras_act_i,
  input  logic              cas_act_i,
  input  logic              we_act_i,
  input  logic              oe_act_i,
  input  logic              cas_fall_i,
  input  logic              rd_evt_i,
  input  logic              wr_evt_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] wbyte_i,
  output logic [LANE_W-1:0] rbyte_o,
  output logic              drv_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rbyte_q;
  logic              drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_evt_i && strobe_act_i) begin
      mem_q[idx_i] <= wbyte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbyte_q <= '0;
      drv_q   <= 1'b0;
    end else begin
      if (rd_evt_i && strobe_act_i) rbyte_q <= mem_q[idx_i];
      // EDO: hold until disabled or next strobe fall
      if (!oe_act_i || we_act_i || (!ras_act_i && !cas_act_i)) drv_q <= 1'b0;
      else if (rd_evt_i && strobe_act_i)                       drv_q <= 1'b1;
      else if (cas_fall_i)                                     drv_q <= 1'b0;
    end
  end

  assign rbyte_o = rbyte_q;
  assign drv_o   = drv_q;

  AST_DRV_OWN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(strobe_act_i)); // R1
  AST_DRV_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_act_i |=> !drv_q); // R4
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_act_i && !cas_act_i) |=> !drv_q); // R8
  AST_LWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_act_i |=> !drv_q); // R6
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder import dcd_pkg::*; #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_ROW_W = 2,
  parameter int unsigned MEM_COL_W = 2,
  parameter int unsigned LANES     = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ras_ni,
  input  logic [LANES-1:0]          cas_ni,
  input  logic                      we_ni,
  input  logic                      oe_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic [LANES-1:0]          dq_oe_o,
  output logic [2:0]                cyc_kind_o,
  output logic                      cyc_valid_o,
  output logic [ADDR_W-1:0]         row_o,
  output logic [ADDR_W-1:0]         rfsh_ctr_o
);
  localparam int unsigned IDX_W = MEM_ROW_W + MEM_COL_W;
  localparam int unsigned S_RAS = 0, S_CAS = 1, S_WE = 2, S_OE = 3;

  logic [LANES-1:0]  strobe_act;
  logic [3:0]        act, prev;
  logic              ras_fall, ras_rise, cas_fall, we_fall, oe_fall;
  logic              rd_evt, wr_evt, rfsh_evt;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] ctr;
  cyc_kind_e         kind;

  assign strobe_act = ~cas_ni;
  assign act[S_RAS] = ~ras_ni;
  assign act[S_CAS] = |strobe_act;  // first to fall, last to rise
  assign act[S_WE]  = ~we_ni;
  assign act[S_OE]  = ~oe_ni;

  dcd_sampler #(.NSIG(4)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .prev_o (prev)
  );

  assign ras_fall = act[S_RAS] & ~prev[S_RAS];
  assign ras_rise = ~act[S_RAS] & prev[S_RAS];
  assign cas_fall = act[S_CAS] & ~prev[S_CAS];
  assign we_fall  = act[S_WE] & ~prev[S_WE];
  assign oe_fall  = act[S_OE] & ~prev[S_OE];

  dcd_refresh_ctr #(.W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rfsh_evt),
    .cnt_o  (ctr)
  );

  dcd_classifier #(
    .ADDR_W    (ADDR_W),
    .MEM_ROW_W (MEM_ROW_W),
    .MEM_COL_W (MEM_COL_W)
  ) u_cls (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_act_i  (act[S_RAS]),
    .cas_act_i  (act[S_CAS]),
    .we_act_i   (act[S_WE]),
    .oe_act_i   (act[S_OE]),
    .ras_fall_i (ras_fall),
    .ras_rise_i (ras_rise),
    .cas_fall_i (cas_fall),
    .we_fall_i  (we_fall),
    .oe_fall_i  (oe_fall),
    .addr_i     (addr_i),
    .ctr_i      (ctr),
    .rd_evt_o   (rd_evt),
    .wr_evt_o   (wr_evt),
    .rfsh_evt_o (rfsh_evt),
    .idx_o      (idx),
    .row_o      (row_o),
    .kind_o     (kind),
    .valid_o    (cyc_valid_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dcd_lane #(.IDX_W(IDX_W)) u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .strobe_act_i (strobe_act[l]),
      .ras_act_i    (act[S_RAS]),
      .cas_act_i    (act[S_CAS]),
      .we_act_i     (act[S_WE]),
      .oe_act_i     (act[S_OE]),
      .cas_fall_i   (cas_fall),
      .rd_evt_i     (rd_evt),
      .wr_evt_i     (wr_evt),
      .idx_i        (idx),
      .wbyte_i      (dq_i[l*LANE_W +: LANE_W]),
      .rbyte_o      (dq_o[l*LANE_W +: LANE_W]),
      .drv_o        (dq_oe_o[l])
    );
  end

  assign cyc_kind_o = kind;
  assign rfsh_ctr_o = ctr;

  AST_EWR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && cyc_kind_o == CYC_EWR) |-> dq_oe_o == '0); // R5
  AST_RONLY_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && cyc_kind_o == CYC_RONLY) |-> $stable(rfsh_ctr_o)); // R3
endmodule

// File: tb/dram_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ras_ni = 1'b1;
  logic [1:0]  cas_ni = 2'b11;
  logic        we_ni = 1'b1;
  logic        oe_ni = 1'b1;
  logic [11:0] addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic [2:0]  cyc_kind_o;
  logic        cyc_valid_o;
  logic [11:0] row_o;
  logic [11:0] rfsh_ctr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dram_cycle_decoder dut_i (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni, .addr_i, .dq_i,
    .dq_o, .dq_oe_o, .cyc_kind_o, .cyc_valid_o, .row_o, .rfsh_ctr_o
  );

  typedef struct packed {
    logic        ras, cl, ch, we, oe;
    logic [11:0] addr;
    logic [15:0] wd;
    logic        vld;
    logic [2:0]  kind;
    logic [1:0]  drv;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'h001, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 12'h001, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 12'h002, 16'hA5C3, 1'b1, 3'd2, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 12'h002, 16'hA5C3, 1'b0, 3'd2, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'h001, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 12'h002, 16'h0000, 1'b1, 3'd1, 2'b11, 16'hA5C3},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 12'h002, 16'h0000, 1'b0, 3'd1, 2'b11, 16'hA5C3},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 12'h003, 16'h0000, 1'b1, 3'd1, 2'b01, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 12'h003, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'h002, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 12'h001, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 12'h001, 16'h7E11, 1'b1, 3'd3, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'hABC, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'hABC, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'hABC, 16'h0000, 1'b1, 3'd4, 2'b00, 16'h0000},
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd4, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 12'h555, 16'h0000, 1'b1, 3'd5, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'h002, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 12'h001, 16'h0000, 1'b1, 3'd1, 2'b11, 16'h7E00},
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 12'h001, 16'h0000, 1'b0, 3'd1, 2'b11, 16'h7E00},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 12'h001, 16'h0000, 1'b1, 3'd6, 2'b11, 16'h7E00},
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 12'h001, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 12'h002, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 12'h002, 16'h0000, 1'b1, 3'd1, 2'b11, 16'hA5C3},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 12'h002, 16'h0000, 1'b0, 3'd1, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000, 16'h0000, 1'b0, 3'd0, 2'b00, 16'h0000}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic r, input logic l, input logic u, input logic w, input logic o,
                     input logic [11:0] a, input logic [15:0] d);
    ras_ni = r; cas_ni = {u, l}; we_ni = w; oe_ni = o; addr_i = a; dq_i = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    put(1, 1, 1, 1, 1, 12'h000, 16'h0000);
  endtask

  task automatic cbr(input logic [11:0] a);
    put(1, 0, 0, 1, 1, a, 16'h0000);
    put(0, 0, 0, 1, 1, a, 16'h0000);
    idle();
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] d);
    return {{8{d[1]}}, {8{d[0]}}};
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R11 reset state
    chk("R11", "kind", 32'(cyc_kind_o), 0);
    chk("R11", "valid", 32'(cyc_valid_o), 0);
    chk("R11", "drive", 32'(dq_oe_o), 0);
    chk("R11", "counter", 32'(rfsh_ctr_o), 0);
    chk("R11", "row", 32'(row_o), 0);

    // table: R4 read, R5 early, R6 late, R7 hold, R8 idle off, R9 hidden, R10 codes, R12 page
    for (int i = 0; i < NV; i++) begin
      put(VEC[i].ras, VEC[i].cl, VEC[i].ch, VEC[i].we, VEC[i].oe, VEC[i].addr, VEC[i].wd);
      chk("R10", $sformatf("vec%0d valid", i), 32'(cyc_valid_o), 32'(VEC[i].vld));
      chk("R10", $sformatf("vec%0d kind", i), 32'(cyc_kind_o), 32'(VEC[i].kind));
      chk("R7/R8", $sformatf("vec%0d drive", i), 32'(dq_oe_o), 32'(VEC[i].drv));
      if (VEC[i].drv != 2'b00)
        chk("R4", $sformatf("vec%0d data", i), 32'(dq_o & lmask(VEC[i].drv)), 32'(VEC[i].rd));
    end
    chk("R9", "counter after cbr+hidden", 32'(rfsh_ctr_o), 2);

    // R3 row-only refresh
    put(0, 1, 1, 1, 1, 12'h123, 16'h0);
    put(0, 1, 1, 1, 1, 12'h000, 16'h0);
    put(1, 1, 1, 1, 1, 12'h000, 16'h0);
    chk("R3", "valid", 32'(cyc_valid_o), 1);
    chk("R3", "kind", 32'(cyc_kind_o), 4);
    chk("R3", "row", 32'(row_o), 32'h123);
    chk("R3", "counter unchanged", 32'(rfsh_ctr_o), 2);

    // R2 counter refresh ignores address
    put(1, 0, 0, 1, 1, 12'hFFF, 16'h0);
    put(0, 0, 0, 1, 1, 12'hFFF, 16'h0);
    chk("R2", "kind", 32'(cyc_kind_o), 5);
    chk("R2", "row from counter", 32'(row_o), 2);
    chk("R2", "counter step", 32'(rfsh_ctr_o), 3);
    idle();

    // R5 lower-only early write, R1 lane mapping on read back
    put(0, 1, 1, 1, 1, 12'h003, 16'h0);
    put(0, 1, 1, 0, 1, 12'h003, 16'h0);
    put(0, 0, 1, 0, 1, 12'h000, 16'h1142);
    chk("R5", "kind", 32'(cyc_kind_o), 2);
    chk("R5", "no drive", 32'(dq_oe_o), 0);
    idle();
    put(0, 1, 1, 1, 1, 12'h003, 16'h0);
    put(0, 0, 0, 1, 0, 12'h000, 16'h0);
    chk("R1", "drive both", 32'(dq_oe_o), 3);
    chk("R5", "lower only written", 32'(dq_o), 32'h0042);
    idle();

    // R1 merged strobe: first fall / last rise
    put(0, 1, 1, 1, 1, 12'h001, 16'h0);
    put(0, 0, 1, 1, 0, 12'h002, 16'h0);
    chk("R1", "lower-only drive", 32'(dq_oe_o), 1);
    chk("R1", "lower data", 32'(dq_o & 16'h00FF), 32'h00C3);
    put(0, 0, 0, 1, 0, 12'h002, 16'h0);
    chk("R1", "late upper fall no event", 32'(cyc_valid_o), 0);
    put(0, 1, 0, 1, 0, 12'h002, 16'h0);
    put(0, 0, 0, 1, 0, 12'h003, 16'h0);
    chk("R1", "strobe never rose no event", 32'(cyc_valid_o), 0);
    chk("R1", "drive held", 32'(dq_oe_o), 1);
    // R12 new column within the same row period
    put(0, 1, 1, 1, 0, 12'h003, 16'h0);
    put(0, 0, 0, 1, 0, 12'h003, 16'h0);
    chk("R12", "new read", 32'(cyc_valid_o), 1);
    chk("R12", "column 3 data", 32'(dq_o), 32'h0000);
    put(0, 1, 1, 1, 0, 12'h003, 16'h0);
    put(0, 0, 0, 1, 0, 12'h002, 16'h0);
    chk("R12", "column 2 data", 32'(dq_o), 32'hA5C3);
    idle();

    // R6 late write with OE low: drive off while WE low, latched column
    put(0, 1, 1, 1, 1, 12'h002, 16'h0);
    put(0, 0, 0, 1, 0, 12'h001, 16'h0);
    chk("R6", "read before", 32'(dq_o), 32'h7E00);
    put(0, 0, 0, 0, 0, 12'hFFE, 16'h1234);
    chk("R6", "kind", 32'(cyc_kind_o), 3);
    chk("R6", "drive off", 32'(dq_oe_o), 0);
    idle();
    put(0, 1, 1, 1, 1, 12'h002, 16'h0);
    put(0, 0, 0, 1, 0, 12'h001, 16'h0);
    chk("R6", "read back", 32'(dq_o), 32'h1234);
    idle();

    // R2 wrap
    for (int k = 0; k < 5000 && rfsh_ctr_o != 12'hFFF; k++) cbr(12'h000);
    chk("R2", "reach top", 32'(rfsh_ctr_o), 32'hFFF);
    cbr(12'h000);
    chk("R2", "wrap to zero", 32'(rfsh_ctr_o), 0);
    chk("R2", "row was top", 32'(row_o), 32'hFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule